// File: doc/BRIEF.md
# Modifier-Driven Address Generation Unit

This block produces data-memory addresses from a bank of four pointer registers. Each pointer has its own offset register and its own modifier register. On every cycle the pointer named by the select input appears on the address output. On the next clock edge that pointer can be updated in place. The modifier of the pointer, not the caller, decides how the update is done: as a plain linear step, as a wrap inside a circular buffer, or as a reverse-carry step that walks an array in bit-reversed order for FFT data reordering.

The step is either one or the pointer's own offset register, added or subtracted. A write port loads any pointer, offset or modifier. Software sets up a buffer once and then issues only select and update codes. Two copies of the block can produce addresses for two memories in the same cycle.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset every pointer and every offset is 0 and every modifier is 16'hFFFF, so every pointer starts in linear mode.
- R2: `addr_o` always equals the current value of the pointer picked by `ptr_sel_i`. The value is the one before any update, and an update becomes visible from the cycle after the clock edge.
- R3: Update codes on `upd_i`: 0 keeps the pointer, 1 adds one, 2 subtracts one, 3 adds the pointer's offset, 4 subtracts the pointer's offset. Codes 5 to 7 change nothing. Only the selected pointer is updated.
- R4: Modifier 16'hFFFF, and any modifier from 16'h8000 to 16'hFFFE, gives linear arithmetic modulo 2^16.
- R5: A modifier M from 1 to 32767 gives a circular buffer of length L = M+1. Its base is the pointer with its low k bits cleared, where 2^k is the smallest power of two that is at least L. The result is base + ((p - base ± step) mod L). The step must not exceed M, and the pointer must start inside [base, base+M].
- R6: Modifier 0 gives reverse-carry arithmetic. The result is the bit reversal of (reverse(p) ± reverse(step)) mod 2^16.
- R7: A write with `wr_en_i` set stores `wr_data_i` at the next edge into entry `wr_idx_i`. `wr_kind_i` selects the register: 0 for a pointer, 1 for an offset, 2 for a modifier. Kind 3 writes nothing.
- R8: When a pointer write and an update of the same pointer happen in the same cycle, the written value wins.
- R9: An update uses the offset and modifier values from before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_sel_i | input | 2 | Pointer selected for the address and the update |
| upd_i | input | 3 | Post-update code |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Register kind to write: pointer, offset or modifier |
| wr_idx_i | input | 2 | Index of the register to write |
| wr_data_i | input | 16 | Write data |
| addr_o | output | 16 | Effective address (the pre-update pointer) |

## Verification
The bench sends long mixed runs through a circular buffer whose length is not a power of two. A design with a wrong base mask or wrong wrap correction would leave the window, or would miss wrap-around on increments and on decrements. A reverse-carry pointer steps through both adds and subtracts. A design whose carry ran the wrong way would produce plain linear addresses there. The bench also covers the reserved modifier range, decrement below zero, and the undefined update codes. It drives same-cycle collisions between a write and an update. A design with the wrong priority would keep the updated pointer. A design that fed the new offset or modifier into the update would take a step of the wrong size.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    UPD_NONE = 3'd0,
    UPD_INC  = 3'd1,
    UPD_DEC  = 3'd2,
    UPD_ADD  = 3'd3,
    UPD_SUB  = 3'd4
  } upd_e;

  typedef enum logic [1:0] {
    WK_PTR  = 2'd0,
    WK_OFF  = 2'd1,
    WK_MOD  = 2'd2,
    WK_NONE = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/agu_step.sv
module agu_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] step_i,
  input  logic          sub_i,
  input  logic [AW-1:0] mod_i,
  output logic [AW-1:0] nxt_o
);
  function automatic logic [AW-1:0] rev(input logic [AW-1:0] v);
    for (int i = 0; i < AW; i++) rev[i] = v[AW-1-i];
  endfunction

  logic          is_rev, is_mod;
  logic [AW-1:0] mask, off, lin, brv, modv;
  logic [AW:0]   len, tmp;

  assign is_rev = (mod_i == '0);
  assign is_mod = !is_rev && !mod_i[AW-1];

  always_comb begin
    mask = mod_i;
    for (int sh = 1; sh < AW; sh = sh * 2) mask = mask | (mask >> sh);
  end

  assign off = ptr_i & mask;
  assign len = {1'b0, mod_i} + 1'b1;
  assign lin = sub_i ? ptr_i - step_i : ptr_i + step_i;
  assign brv = sub_i ? rev(rev(ptr_i) - rev(step_i)) : rev(rev(ptr_i) + rev(step_i));

  always_comb begin
    if (sub_i) tmp = (off >= step_i) ? {1'b0, off - step_i} : {1'b0, off} + len - {1'b0, step_i};
    else begin
      tmp = {1'b0, off} + {1'b0, step_i};
      if (tmp > {1'b0, mod_i}) tmp = tmp - len;
    end
    modv = (ptr_i & ~mask) | (tmp[AW-1:0] & mask);
  end

  assign nxt_o = is_rev ? brv : (is_mod ? modv : lin);

  // result must stay inside [base, base+M] for legal operands
  always_comb begin
    if (is_mod && off <= mod_i && step_i <= mod_i) begin
      assert_mod_window_R5: assert (((nxt_o & ~mask) == (ptr_i & ~mask)) && ((nxt_o & mask) <= mod_i));
    end
  end
endmodule

// File: rtl/agu_regs.sv
module agu_regs
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int NP = 4,
  localparam int IW = $clog2(NP)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   upd_en_i,
  input  logic [IW-1:0]          upd_idx_i,
  input  logic [AW-1:0]          upd_val_i,
  input  logic                   wr_en_i,
  input  logic [1:0]             wr_kind_i,
  input  logic [IW-1:0]          wr_idx_i,
  input  logic [AW-1:0]          wr_data_i,
  output logic [NP-1:0][AW-1:0]  ptr_o,
  output logic [NP-1:0][AW-1:0]  off_o,
  output logic [NP-1:0][AW-1:0]  mod_o
);
  for (genvar g = 0; g < NP; g++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_o[g] <= '0;
        off_o[g] <= '0;
        mod_o[g] <= '1;
      end else begin
        // a pointer write overrides an update in the same cycle
        if (hit && wr_kind_i == WK_PTR)             ptr_o[g] <= wr_data_i;
        else if (upd_en_i && upd_idx_i == IW'(g))   ptr_o[g] <= upd_val_i;
        if (hit && wr_kind_i == WK_OFF)             off_o[g] <= wr_data_i;
        if (hit && wr_kind_i == WK_MOD)             mod_o[g] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int NP = 4,
  localparam int IW = $clog2(NP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] ptr_sel_i,
  input  logic [2:0]    upd_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  output logic [AW-1:0] addr_o
);
  logic [NP-1:0][AW-1:0] ptr_q, off_q, mod_q;
  logic [AW-1:0]         step, nxt;
  logic                  upd_en, sub;
  upd_e                  upd;

  assign upd    = upd_e'(upd_i);
  assign upd_en = (upd == UPD_INC) || (upd == UPD_DEC) || (upd == UPD_ADD) || (upd == UPD_SUB);
  assign sub    = (upd == UPD_DEC) || (upd == UPD_SUB);
  assign step   = ((upd == UPD_INC) || (upd == UPD_DEC)) ? AW'(1) : off_q[ptr_sel_i];
  assign addr_o = ptr_q[ptr_sel_i];

  agu_step #(.AW(AW)) u_step (
    .ptr_i  (ptr_q[ptr_sel_i]),
    .step_i (step),
    .sub_i  (sub),
    .mod_i  (mod_q[ptr_sel_i]),
    .nxt_o  (nxt)
  );

  agu_regs #(.AW(AW), .NP(NP)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_en_i  (upd_en),
    .upd_idx_i (ptr_sel_i),
    .upd_val_i (nxt),
    .wr_en_i   (wr_en_i),
    .wr_kind_i (wr_kind_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .ptr_o     (ptr_q),
    .off_o     (off_q),
    .mod_o     (mod_q)
  );

  assert_wr_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == 2'd0) |=> ptr_q[$past(wr_idx_i)] == $past(wr_data_i));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && (upd_i == 3'd0 || upd_i > 3'd4)) |=> $stable(ptr_q));

  assert_lin_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && upd_i == 3'd1 && mod_q[ptr_sel_i] == '1) |=>
      ptr_q[$past(ptr_sel_i)] == AW'($past(addr_o) + 1'b1));

  assert_mod_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == 2'd2) |=> mod_q[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: tb/addr_gen_unit_bench.sv
module addr_gen_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  ptr_sel_i = '0;
  logic [2:0]  upd_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_kind_i = '0;
  logic [1:0]  wr_idx_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] addr_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_ptr[4], m_off[4], m_mod[4];

  always #2.5 clk_i = ~clk_i;

  addr_gen_unit u_addr_gen_unit (.*);

  function automatic int rev16(int v);
    int r = 0;
    for (int i = 0; i < 16; i++) if (v & (1 << i)) r |= 1 << (15 - i);
    return r;
  endfunction

  function automatic string mode_tag(int s);
    if (m_mod[s] == 0) return "R6";
    if (m_mod[s] >= 'h8000) return "R4";
    return "R5";
  endfunction

  function automatic int model_next(int p, int st, bit dn, int m);
    if (m == 0) return dn ? rev16((rev16(p) - rev16(st)) & 'hFFFF) : rev16((rev16(p) + rev16(st)) & 'hFFFF);
    if (m >= 'h8000) return dn ? (p - st) & 'hFFFF : (p + st) & 'hFFFF;
    begin
      int len = m + 1, blk = 1, base, o;
      while (blk < len) blk = blk * 2;
      base = p - (p % blk);
      o = p - base;
      o = dn ? (o - st + len) % len : (o + st) % len;
      return base + o;
    end
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int s, input int u, input bit we, input int wk, input int wi,
                     input int wd, input string tag);
    int np[4], no[4], nm[4];
    @(negedge clk_i);
    ptr_sel_i = 2'(s); upd_i = 3'(u); wr_en_i = we;
    wr_kind_i = 2'(wk); wr_idx_i = 2'(wi); wr_data_i = 16'(wd);
    #1;
    check((tag != "") ? tag : {"R2/", mode_tag(s)}, int'(addr_o), m_ptr[s]);
    np = m_ptr; no = m_off; nm = m_mod;
    if (u >= 1 && u <= 4)  // R3, R9: old offset and modifier
      np[s] = model_next(m_ptr[s], (u <= 2) ? 1 : m_off[s], (u == 2 || u == 4), m_mod[s]);
    if (we) begin  // R7, R8
      if (wk == 0) np[wi] = wd;
      if (wk == 1) no[wi] = wd;
      if (wk == 2) nm[wi] = wd;
    end
    @(posedge clk_i);
    m_ptr = np; m_off = no; m_mod = nm;
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_ptr[i] = 0; m_off[i] = 0; m_mod[i] = 'hFFFF; end
    #12 rst_ni = 1'b1;
    // R1: reset values
    for (int i = 0; i < 4; i++) cyc(i, 0, 0, 0, 0, 0, "R1");
    cyc(0, 2, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, "R4");  // decrement below zero wraps to FFFF
    // R7: setup
    cyc(0, 0, 1, 0, 1, 'h0043, "R7");
    cyc(0, 0, 1, 2, 1, 9, "R7");
    cyc(0, 0, 1, 1, 1, 4, "R7");
    cyc(0, 0, 1, 2, 2, 0, "R7");
    cyc(0, 0, 1, 1, 2, 'h0080, "R7");
    cyc(0, 0, 1, 0, 3, 'h0104, "R7");
    cyc(0, 0, 1, 2, 3, 5, "R7");
    cyc(0, 0, 1, 1, 3, 2, "R7");
    cyc(0, 0, 1, 3, 0, 'h5555, "R7");  // kind 3 writes nothing
    // R5 directed wrap both ways
    for (int i = 0; i < 8; i++) cyc(1, 3, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 8; i++) cyc(3, 4, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 6; i++) cyc(3, 2, 0, 0, 0, 0, "R5");
    // R6 directed
    for (int i = 0; i < 6; i++) cyc(2, 3, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 3; i++) cyc(2, 4, 0, 0, 0, 0, "R6");
    // mixed run: R3 codes incl. 5..7, R9 collisions on linear/bitrev pointers
    for (int i = 0; i < 1500; i++) begin
      int s = $urandom % 4, u = $urandom % 8, r = $urandom % 8, wi;
      bit we = (r == 0);
      wi = ($urandom % 2) ? 0 : 2;
      cyc(s, u, we, $urandom % 2, wi, $urandom & 'hFFFF, "");
    end
    // R4: reserved modifier acts linear
    cyc(0, 0, 1, 2, 3, 'h9000, "R4");
    cyc(0, 0, 1, 0, 3, 'hFFFE, "R4");
    cyc(0, 0, 1, 1, 3, 3, "R4");
    cyc(3, 3, 0, 0, 0, 0, "R4");
    cyc(3, 0, 0, 0, 0, 0, "R4");
    // R8: write beats update on same pointer
    cyc(0, 1, 1, 0, 0, 'h1234, "R8");
    cyc(0, 0, 0, 0, 0, 0, "R8");
    // R9: offset write with add-offset on same pointer uses old offset
    cyc(0, 0, 1, 1, 0, 7, "R9");
    cyc(0, 3, 1, 1, 0, 100, "R9");
    cyc(0, 3, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R9");
    // R3: invalid codes keep pointer
    cyc(0, 6, 0, 0, 0, 0, "R3");
    cyc(0, 7, 0, 0, 0, 0, "R3");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule